// File: doc/BRIEF.md
# Event Interrupt Policy Register

This block keeps one interrupt enable for each of five event logs: informational, warning, failure, fatal and dynamic capacity. A command port accepts a write or a read. A write carries one settings byte for each log. Each present byte sets or clears that log's enable, depending on its mode field. A read returns the current settings of all five logs as one packed five-byte response. Each response comes back one cycle after its command, with a status code and a response length.

Each log also has an event strobe input. When a log's strobe arrives and its enable is set, the matching interrupt request output is high for one cycle. The informational, warning, failure and fatal logs report their own interrupt vector number on read; these numbers arrive on an input port. The dynamic-capacity log uses the informational log's vector, so its read-back byte holds only the mode code. Its settings byte is optional in a write: a four-byte write leaves its enable untouched.

Top module: `evt_irq_policy`

## Requirements
- R1: After synchronous reset, all five enables are clear, rsp_valid is low and irq_req is all zero; a read then returns five zero bytes.
- R2: A write whose length is below four bytes is rejected with status 1 (bad length), response length 0, and changes no enable.
- R3: Payload byte k (bits 8k+7:8k) is log k, in the order 0 informational, 1 warning, 2 failure, 3 fatal, 4 dynamic capacity. A log is enabled only when bits 1:0 of its byte equal 2'b01 (MSI/MSI-X mode); the values 00, 10 and 11 disable it, and bits 7:2 are ignored on write.
- R4: A write of exactly four bytes updates logs 0 to 3, leaves the dynamic-capacity enable as it was, and responds with status 0 (success) and response length 0.
- R5: A write of five or more bytes also updates the dynamic-capacity enable from byte 4; bytes past the fifth are ignored.
- R6: A read of length 0 responds with status 0 and response length 5. For logs 0 to 3, byte k is 8'h00 when disabled; when enabled it holds the vector number of log k in bits 7:4, zero in bits 3:2 and 2'b01 in bits 1:0. The vector of log k is vec_in[4k+3:4k].
- R7: On read, an enabled dynamic-capacity log returns exactly 8'h01, whatever the vectors are.
- R8: A read with a nonzero length is rejected with status 1, response length 0, a zero payload, and no enable change.
- R9: Every command cycle produces exactly one response cycle, on the next cycle; back-to-back commands give back-to-back responses in order.
- R10: irq_req[k] is high for exactly the cycle after evt_strobe[k] is high, and only if log k's enable is set at that strobe; a disabled log raises nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write settings, 0 = read settings |
| cmd_len | input | 8 | Command payload length in bytes |
| cmd_payload | input | 40 | Settings bytes, byte k for log k |
| vec_in | input | 16 | Interrupt vector numbers, 4 bits for each of logs 0 to 3 |
| evt_strobe | input | 5 | New-event strobe, one bit per log |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_status | output | 2 | 0 success, 1 bad length |
| rsp_len | output | 8 | Response payload length in bytes |
| rsp_payload | output | 40 | Read-back settings, byte k for log k |
| irq_req | output | 5 | One-cycle interrupt request per log |

## Verification
The bench builds the block with its default values: 4-bit vector numbers, an 8-bit length field, a four-byte minimum and a five-byte full payload. The 8-bit length field lets the bench send writes longer than five bytes and reads with a nonzero length, as well as lengths 0, 3, 4 and 5 around the minimum. The 4-bit vectors are set to a different value for each log. This shows that each read-back byte carries its own log's vector and that the dynamic-capacity byte never does.

// File: rtl/eip_pkg.sv
package eip_pkg;

    localparam int LOGS       = 5;
    localparam int VEC_W      = 4;
    localparam int MODE_W     = 2;
    localparam int SET_W      = 8;
    localparam int LEN_W      = 8;
    localparam int MIN_LEN    = 4;
    localparam int FULL_LEN   = 5;
    localparam int SHARED_LOG = 4;
    localparam int PAY_W      = LOGS * SET_W;
    localparam int VECS_W     = (LOGS - 1) * VEC_W;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF  = 2'b00,
        MODE_MSI  = 2'b01,
        MODE_FW   = 2'b10,
        MODE_RSVD = 2'b11
    } irq_mode_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_BAD_LEN = 2'd1
    } eip_status_e;

    typedef struct packed {
        logic             write;
        logic [LEN_W-1:0] len;
        logic [PAY_W-1:0] payload;
    } eip_cmd_t;

    typedef struct packed {
        eip_status_e      status;
        logic [LEN_W-1:0] len;
        logic [PAY_W-1:0] payload;
    } eip_rsp_t;

    // A settings byte turns its log on only in MSI/MSI-X mode.
    function automatic logic mode_enables(input logic [SET_W-1:0] b);
        return b[MODE_W-1:0] == MODE_MSI;
    endfunction

    // Builds the read-back byte for one log.
    function automatic logic [SET_W-1:0] pack_setting(input logic en,
                                                      input logic [VEC_W-1:0] vec,
                                                      input logic shared);
        logic [SET_W-1:0] b;
        b = '0;
        if (en) begin
            b[MODE_W-1:0] = MODE_MSI;
            if (!shared) b[SET_W-1 -: VEC_W] = vec;
        end
        return b;
    endfunction

endpackage

// File: rtl/eip_decode.sv
module eip_decode
    import eip_pkg::*;
(
    input  eip_cmd_t         cmd,
    input  logic [LOGS-1:0]  en_cur,
    output logic             write_ok,
    output logic             read_ok,
    output logic [LOGS-1:0]  en_next
);

    always_comb begin
        write_ok = cmd.write && (cmd.len >= LEN_W'(MIN_LEN));
        read_ok  = !cmd.write && (cmd.len == '0);
    end

    // A log's byte counts only when the write is long enough to carry it.
    for (genvar k = 0; k < LOGS; k++) begin : g_log
        logic present;
        always_comb begin
            present    = write_ok && (cmd.len > LEN_W'(k));
            en_next[k] = present ? mode_enables(cmd.payload[k*SET_W +: SET_W])
                                 : en_cur[k];
        end
    end

endmodule

// File: rtl/eip_encode.sv
module eip_encode
    import eip_pkg::*;
(
    input  logic [LOGS-1:0]   en,
    input  logic [VECS_W-1:0] vec_in,
    output logic [PAY_W-1:0]  settings
);

    for (genvar k = 0; k < LOGS; k++) begin : g_byte
        if (k == SHARED_LOG) begin : g_shared
            always_comb settings[k*SET_W +: SET_W] = pack_setting(en[k], '0, 1'b1);
        end else begin : g_own
            always_comb settings[k*SET_W +: SET_W] =
                pack_setting(en[k], vec_in[k*VEC_W +: VEC_W], 1'b0);
        end
    end

endmodule

// File: rtl/eip_irq_gate.sv
module eip_irq_gate
    import eip_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [LOGS-1:0] en,
    input  logic [LOGS-1:0] strobe,
    output logic [LOGS-1:0] irq
);

    for (genvar k = 0; k < LOGS; k++) begin : g_gate
        always_ff @(posedge clk) begin
            if (rst) irq[k] <= 1'b0;
            else     irq[k] <= strobe[k] & en[k];
        end
    end

endmodule

// File: rtl/evt_irq_policy.sv
module evt_irq_policy
    import eip_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_valid,
    input  logic                    cmd_write,
    input  logic [LEN_W-1:0]        cmd_len,
    input  logic [PAY_W-1:0]        cmd_payload,
    input  logic [VECS_W-1:0]       vec_in,
    input  logic [LOGS-1:0]         evt_strobe,
    output logic                    rsp_valid,
    output logic [1:0]              rsp_status,
    output logic [LEN_W-1:0]        rsp_len,
    output logic [PAY_W-1:0]        rsp_payload,
    output logic [LOGS-1:0]         irq_req
);

    eip_cmd_t        cmd;
    eip_rsp_t        rsp_d, rsp_q;
    logic [LOGS-1:0] en_q, en_next;
    logic [PAY_W-1:0] settings;
    logic            write_ok, read_ok;

    always_comb begin
        cmd.write   = cmd_write;
        cmd.len     = cmd_len;
        cmd.payload = cmd_payload;
    end

    eip_decode u_decode (
        .cmd      (cmd),
        .en_cur   (en_q),
        .write_ok (write_ok),
        .read_ok  (read_ok),
        .en_next  (en_next)
    );

    eip_encode u_encode (
        .en       (en_q),
        .vec_in   (vec_in),
        .settings (settings)
    );

    eip_irq_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .en     (en_q),
        .strobe (evt_strobe),
        .irq    (irq_req)
    );

    always_comb begin
        rsp_d = '0;
        if (read_ok) begin
            rsp_d.status  = ST_OK;
            rsp_d.len     = LEN_W'(FULL_LEN);
            rsp_d.payload = settings;
        end else if (write_ok) begin
            rsp_d.status = ST_OK;
        end else begin
            rsp_d.status = ST_BAD_LEN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            rsp_q     <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= cmd_valid;
            if (cmd_valid) begin
                rsp_q <= rsp_d;
                if (write_ok) en_q <= en_next;
            end
        end
    end

    always_comb begin
        rsp_status  = rsp_q.status;
        rsp_len     = rsp_q.len;
        rsp_payload = rsp_q.payload;
    end

endmodule

// File: rtl/evt_irq_policy_chk.sv
module evt_irq_policy_chk
    import eip_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_write,
    input logic [LEN_W-1:0]  cmd_len,
    input logic [LOGS-1:0]   evt_strobe,
    input logic [LOGS-1:0]   en_q,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic [LEN_W-1:0]  rsp_len,
    input logic [PAY_W-1:0]  rsp_payload,
    input logic [LOGS-1:0]   irq_req
);

    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid);

    assert_no_stray_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid);

    assert_short_write_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_write && cmd_len < LEN_W'(MIN_LEN))
        |=> (rsp_status == ST_BAD_LEN) && (rsp_len == '0) && $stable(en_q));

    assert_good_write_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_write && cmd_len >= LEN_W'(MIN_LEN))
        |=> (rsp_status == ST_OK) && (rsp_len == '0));

    assert_dyn_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_write && cmd_len == LEN_W'(MIN_LEN))
        |=> en_q[SHARED_LOG] == $past(en_q[SHARED_LOG]));

    assert_dyn_byte_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_len == LEN_W'(FULL_LEN))
        |-> (rsp_payload[SHARED_LOG*SET_W +: SET_W] == 8'h00 ||
             rsp_payload[SHARED_LOG*SET_W +: SET_W] == 8'h01));

    assert_irq_needs_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        (|irq_req) |-> ((irq_req & ~$past(evt_strobe)) == '0));

    assert_bad_read_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_write && cmd_len != '0)
        |=> (rsp_status == ST_BAD_LEN) && (rsp_payload == '0));

endmodule

bind evt_irq_policy evt_irq_policy_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_write   (cmd_write),
    .cmd_len     (cmd_len),
    .evt_strobe  (evt_strobe),
    .en_q        (en_q),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status),
    .rsp_len     (rsp_len),
    .rsp_payload (rsp_payload),
    .irq_req     (irq_req)
);

// File: tb/evt_irq_policy_bench.sv
module evt_irq_policy_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [7:0]  cmd_len = '0;
    logic [39:0] cmd_payload = '0;
    logic [15:0] vec_in = 16'hA5C3;
    logic [4:0]  evt_strobe = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [7:0]  rsp_len;
    logic [39:0] rsp_payload;
    logic [4:0]  irq_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]  status;
        logic [7:0]  len;
        logic [39:0] payload;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic [4:0] en_m = '0;

    always #10 clk = ~clk;

    evt_irq_policy u_evt_irq_policy (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_write   (cmd_write),
        .cmd_len     (cmd_len),
        .cmd_payload (cmd_payload),
        .vec_in      (vec_in),
        .evt_strobe  (evt_strobe),
        .rsp_valid   (rsp_valid),
        .rsp_status  (rsp_status),
        .rsp_len     (rsp_len),
        .rsp_payload (rsp_payload),
        .irq_req     (irq_req)
    );

    function automatic logic [39:0] expect_read(input logic [4:0] en, input logic [15:0] v);
        logic [39:0] p;
        p = '0;
        for (int k = 0; k < 4; k++)
            if (en[k]) p[k*8 +: 8] = {v[k*4 +: 4], 2'b00, 2'b01};
        if (en[4]) p[39:32] = 8'h01;
        return p;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Driver: places a command and pushes the response it must produce.
    task automatic issue(input bit wr, input logic [7:0] len,
                         input logic [39:0] pay, input string tag);
        exp_t e;
        e.tag = tag;
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_len = len;
        cmd_payload = pay;
        if (wr) begin
            if (len >= 8'd4) begin
                e.status = 2'd0; e.len = 8'd0; e.payload = '0;
                for (int k = 0; k < 5; k++)
                    if (len > 8'(k)) en_m[k] = (pay[k*8 +: 2] == 2'b01);
            end else begin
                e.status = 2'd1; e.len = 8'd0; e.payload = '0;
            end
        end else begin
            if (len == 8'd0) begin
                e.status = 2'd0; e.len = 8'd5; e.payload = expect_read(en_m, vec_in);
            end else begin
                e.status = 2'd1; e.len = 8'd0; e.payload = '0;
            end
        end
        exp_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Monitor: pops an expectation for every response seen.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected response", 64'(rsp_status), 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_status == e.status, {e.tag, " status"}, 64'(rsp_status), 64'(e.status));
                check(rsp_len == e.len, {e.tag, " len"}, 64'(rsp_len), 64'(e.len));
                check(rsp_payload == e.payload, {e.tag, " payload"}, 64'(rsp_payload), 64'(e.payload));
            end
        end
    end

    task automatic pulse_events(input logic [4:0] mask, input string tag);
        evt_strobe = mask;
        @(negedge clk);
        evt_strobe = '0;
        check(irq_req == (mask & en_m), {tag, " pulse"}, 64'(irq_req), 64'(mask & en_m));
        @(negedge clk);
        check(irq_req == 5'd0, {tag, " one cycle"}, 64'(irq_req), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'h0);
        check(irq_req == 5'd0, "R1 irq_req", 64'(irq_req), 64'h0);
        issue(1'b0, 8'd0, '0, "R1 read after reset");
        pulse_events(5'h1F, "R1 R10 disabled logs");

        // R5 R6 R7: full write enables all five
        issue(1'b1, 8'd5, 40'h01_F1_FD_09_01, "R5 full write");
        issue(1'b0, 8'd0, '0, "R6 R7 read all enabled");

        // R3 R4: four-byte write, mixed modes, dyn byte ignored
        issue(1'b1, 8'd4, 40'h00_F1_03_02_00, "R4 four-byte write");
        issue(1'b0, 8'd0, '0, "R3 R4 read after four-byte write");

        // R10: gating with partial enables
        pulse_events(5'h1F, "R10 all strobes");
        pulse_events(5'h09, "R10 some strobes");

        // R2: short writes rejected, state kept
        issue(1'b1, 8'd3, 40'h00_00_00_00_00, "R2 len3 write");
        issue(1'b1, 8'd0, 40'h00_00_00_00_00, "R2 len0 write");
        issue(1'b0, 8'd0, '0, "R2 read unchanged");

        // R8: read with length rejected
        issue(1'b0, 8'd2, 40'hFF_FF_FF_FF_FF, "R8 read with len");

        // R5: long write, dyn disabled, back-to-back (R9)
        issue(1'b1, 8'd9, 40'h02_01_01_01_01, "R5 R9 long write");
        issue(1'b0, 8'd0, '0, "R5 R9 back-to-back read");
        issue(1'b1, 8'd255, 40'h01_11_22_33_45, "R5 R3 max length write");
        issue(1'b0, 8'd0, '0, "R3 R7 read");
        pulse_events(5'h11, "R10 dyn and info");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 missing responses", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule